// File: doc/BRIEF.md
# Privileged Trap Entry and Return Unit

This unit decides where a processor core goes when it enters or leaves its privileged handler mode. A fault request is a one-cycle pulse carrying a 4-bit fault number. On the next clock edge the unit computes the handler entry address by adding a fixed per-fault offset to a handler base address. It also saves a restart address and, where the rules call for it, turns on a shadow flag. The shadow flag gives eight integer registers (8 to 14 and 25) alternate copies.

Bit 0 of the program counter marks handler mode. A return-from-handler request restores the program counter from the saved restart address. When bit 0 of that address is clear, the return also leaves shadow mode, and every accepted return asks the core to check for interrupts again.

The unit contains the banked integer register file, so the effect of a bank swap can be seen directly on its read port. A request to swap into the bank that is already active does nothing except raise an internal error pulse.

Top module: `trap_unit`

## Requirements
- R1: While reset is asserted and after it is released with no request, the outputs are: pc_o = vec_base + 0x001, npc_o = pc_o + 4, restart_o = 0, shadow_o = 1, and all pulse outputs are 0.
- R2: A trap_valid pulse sets pc_o on the next edge to vec_base plus an offset chosen by trap_code, and sets redirect_o for that one cycle. The offsets by code are:
  - 0 = 0x001, 1 = 0x401, 2 = 0x501, 3 = 0x101
  - 4 = 0x201, 5 = 0x281, 6 = 0x301, 7 = 0x381, 8 = 0x381
  - 9 = 0x181, 10 = 0x181, 11 = 0x081
  - 12 = 0x481, 13 = 0x581, 14 = 0x2001, 15 = 0x501
- R3: npc_o always equals pc_o + 4.
- R4: On a trap, restart_o is loaded with cur_pc. For codes 2, 14 and 15 it is loaded with cur_pc + 4 instead.
- R5: An interrupt trap (code 3) taken while cur_pc bit 0 is 1 leaves restart_o unchanged.
- R6: A trap taken while cur_pc bit 0 is 0 and shadow_o is 0 sets shadow_o. A trap taken while cur_pc bit 0 is 1 leaves shadow_o unchanged.
- R7: While shadow_o is 1, writes and reads of registers 8 to 14 and 25 use the alternate copies. All other registers, and all registers while shadow_o is 0, use the normal copies.
- R8: A return with cur_pc bit 0 set loads pc_o from restart_o and pulses recheck_o. It clears shadow_o only when restart_o bit 0 is 0.
- R9: A return with cur_pc bit 0 clear pulses ret_fault_o and leaves pc_o, shadow_o and restart_o unchanged.
- R10: A request to swap into the mode already active leaves shadow_o unchanged and pulses swap_err_o. The other effects of that trap or return still take place.
- R11: When trap_valid and ret_valid are high in the same cycle, the trap is taken and the return is dropped: no recheck_o and no ret_fault_o.
- R12: rf_rdata shows the register selected by rf_raddr one cycle after rf_raddr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_base | input | PC_W | Handler base address |
| cur_pc | input | PC_W | Program counter of the requesting instruction |
| trap_valid | input | 1 | One-cycle trap request |
| trap_code | input | 4 | Fault number |
| ret_valid | input | 1 | One-cycle return-from-handler request |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | AW | Register write index |
| rf_wdata | input | DW | Register write data |
| rf_raddr | input | AW | Register read index |
| rf_rdata | output | DW | Registered read data |
| pc_o | output | PC_W | Program counter |
| npc_o | output | PC_W | Next program counter |
| restart_o | output | PC_W | Saved restart address |
| shadow_o | output | 1 | Shadow bank active |
| redirect_o | output | 1 | pc_o was reloaded on the last edge |
| recheck_o | output | 1 | Interrupt re-check request after a return |
| ret_fault_o | output | 1 | Return attempted outside handler mode |
| swap_err_o | output | 1 | Swap into the already-active mode was refused |

## Verification
A trap and a return can arrive in the same cycle. The bench raises both requests together while the core is in handler mode. It then checks three things: pc_o lands on the trap vector, restart_o takes the trap's value, and neither recheck_o nor ret_fault_o pulses.

A bank swap and a register access can also coincide with a mode change. The bench checks this by reading shadowed and shared registers on either side of a trap. It expects the read issued in the trap cycle to use the old bank.

// File: rtl/trapu_pkg.sv
package trapu_pkg;

  typedef enum logic [3:0] {
    F_RESET  = 4'd0,  F_MCHK   = 4'd1,  F_ARITH  = 4'd2,  F_INTR   = 4'd3,
    F_DMISSN = 4'd4,  F_DMISSP = 4'd5,  F_ALIGN  = 4'd6,  F_DFAULT = 4'd7,
    F_DACV   = 4'd8,  F_IMISS  = 4'd9,  F_IFAULT = 4'd10, F_IACV   = 4'd11,
    F_OPC    = 4'd12, F_FPOFF  = 4'd13, F_CALL   = 4'd14, F_OVF    = 4'd15
  } fault_e;

  localparam int OFF_W   = 14;
  localparam int SHD_CNT = 8;

  function automatic logic [OFF_W-1:0] vec_offset(input fault_e f);
    case (f)
      F_RESET:           return 14'h0001;
      F_MCHK:            return 14'h0401;
      F_ARITH, F_OVF:    return 14'h0501;
      F_INTR:            return 14'h0101;
      F_DMISSN:          return 14'h0201;
      F_DMISSP:          return 14'h0281;
      F_ALIGN:           return 14'h0301;
      F_DFAULT, F_DACV:  return 14'h0381;
      F_IMISS, F_IFAULT: return 14'h0181;
      F_IACV:            return 14'h0081;
      F_OPC:             return 14'h0481;
      F_FPOFF:           return 14'h0581;
      default:           return 14'h2001;
    endcase
  endfunction

  function automatic logic skips_insn(input fault_e f);
    return (f == F_ARITH) || (f == F_CALL) || (f == F_OVF);
  endfunction

  function automatic logic is_banked(input int unsigned idx);
    return ((idx >= 8) && (idx <= 14)) || (idx == 25);
  endfunction

  function automatic logic [2:0] bank_slot(input int unsigned idx);
    logic [2:0] s;
    s = (idx == 25) ? 3'd7 : 3'(idx - 8);
    return s;
  endfunction

endpackage

// File: rtl/trapu_vector.sv
module trapu_vector
  import trapu_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] base,
  input  logic [3:0]      code,
  output logic [PC_W-1:0] target,
  output logic            skip
);
  fault_e f;

  always_comb begin
    f      = fault_e'(code);
    target = base + PC_W'(vec_offset(f));
    skip   = skips_insn(f);
  end
endmodule

// File: rtl/trapu_ctrl.sv
module trapu_ctrl
  import trapu_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] vec_base,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            trap_valid,
  input  logic [3:0]      trap_code,
  input  logic            ret_valid,
  input  logic [PC_W-1:0] target,
  input  logic            skip,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] npc_q,
  output logic [PC_W-1:0] restart_q,
  output logic            shadow_q,
  output logic            redirect_q,
  output logic            recheck_q,
  output logic            ret_fault_q,
  output logic            swap_err_q
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic in_handler;
  logic is_intr;
  logic [PC_W-1:0] rst_pc;

  always_comb begin
    in_handler = cur_pc[0];
    is_intr    = (fault_e'(trap_code) == F_INTR);
    rst_pc     = vec_base + PC_W'(vec_offset(F_RESET));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= rst_pc;
      npc_q       <= rst_pc + STEP;
      restart_q   <= '0;
      shadow_q    <= 1'b1;
      redirect_q  <= 1'b0;
      recheck_q   <= 1'b0;
      ret_fault_q <= 1'b0;
      swap_err_q  <= 1'b0;
    end else begin
      redirect_q  <= 1'b0;
      recheck_q   <= 1'b0;
      ret_fault_q <= 1'b0;
      swap_err_q  <= 1'b0;
      if (trap_valid) begin
        pc_q       <= target;
        npc_q      <= target + STEP;
        redirect_q <= 1'b1;
        if (!(is_intr && in_handler))
          restart_q <= skip ? (cur_pc + STEP) : cur_pc;
        if (!in_handler) begin
          if (shadow_q) swap_err_q <= 1'b1;
          else          shadow_q   <= 1'b1;
        end
      end else if (ret_valid) begin
        if (!in_handler) begin
          ret_fault_q <= 1'b1;
        end else begin
          pc_q       <= restart_q;
          npc_q      <= restart_q + STEP;
          redirect_q <= 1'b1;
          recheck_q  <= 1'b1;
          if (!restart_q[0]) begin
            if (!shadow_q) swap_err_q <= 1'b1;
            else           shadow_q   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/trapu_rf.sv
module trapu_rf
  import trapu_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          shadow,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] main_mem [NREG];
  logic [DW-1:0] alt_mem  [SHD_CNT];
  logic [DW-1:0] main_rd, alt_rd;
  logic          alt_sel;
  logic          w_alt, r_alt;
  logic [2:0]    w_slot, r_slot;

  always_comb begin
    w_alt  = shadow && is_banked(32'(waddr));
    r_alt  = shadow && is_banked(32'(raddr));
    w_slot = bank_slot(32'(waddr));
    r_slot = bank_slot(32'(raddr));
  end

  always_ff @(posedge clk) begin
    if (we && !w_alt) main_mem[waddr] <= wdata;
    main_rd <= main_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we && w_alt) alt_mem[w_slot] <= wdata;
    alt_rd  <= alt_mem[r_slot];
    alt_sel <= r_alt;
  end

  assign rdata = alt_sel ? alt_rd : main_rd;
endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int PC_W = 32,
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] vec_base,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            trap_valid,
  input  logic [3:0]      trap_code,
  input  logic            ret_valid,
  input  logic            rf_we,
  input  logic [AW-1:0]   rf_waddr,
  input  logic [DW-1:0]   rf_wdata,
  input  logic [AW-1:0]   rf_raddr,
  output logic [DW-1:0]   rf_rdata,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o,
  output logic [PC_W-1:0] restart_o,
  output logic            shadow_o,
  output logic            redirect_o,
  output logic            recheck_o,
  output logic            ret_fault_o,
  output logic            swap_err_o
);
  logic [PC_W-1:0] target;
  logic            skip;

  trapu_vector #(.PC_W(PC_W)) u_vec (
    .base(vec_base), .code(trap_code), .target(target), .skip(skip)
  );

  trapu_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst(rst), .vec_base(vec_base), .cur_pc(cur_pc),
    .trap_valid(trap_valid), .trap_code(trap_code), .ret_valid(ret_valid),
    .target(target), .skip(skip),
    .pc_q(pc_o), .npc_q(npc_o), .restart_q(restart_o), .shadow_q(shadow_o),
    .redirect_q(redirect_o), .recheck_q(recheck_o),
    .ret_fault_q(ret_fault_o), .swap_err_q(swap_err_o)
  );

  trapu_rf #(.NREG(NREG), .DW(DW), .AW(AW)) u_rf (
    .clk(clk), .shadow(shadow_o), .we(rf_we), .waddr(rf_waddr),
    .wdata(rf_wdata), .raddr(rf_raddr), .rdata(rf_rdata)
  );
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int PC_W = 32,
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] vec_base,
  input logic [PC_W-1:0] cur_pc,
  input logic            trap_valid,
  input logic [3:0]      trap_code,
  input logic            ret_valid,
  input logic            rf_we,
  input logic [AW-1:0]   rf_waddr,
  input logic [DW-1:0]   rf_wdata,
  input logic [AW-1:0]   rf_raddr,
  input logic [DW-1:0]   rf_rdata,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] npc_o,
  input logic [PC_W-1:0] restart_o,
  input logic            shadow_o,
  input logic            redirect_o,
  input logic            recheck_o,
  input logic            ret_fault_o,
  input logic            swap_err_o
);
  a_r3_npc_follows: assert property (@(posedge clk) disable iff (rst)
    npc_o == pc_o + PC_W'(4));

  a_r6_enter_shadow: assert property (@(posedge clk) disable iff (rst)
    trap_valid && !cur_pc[0] && !shadow_o |=> shadow_o && !swap_err_o);

  a_r5_intr_keeps_restart: assert property (@(posedge clk) disable iff (rst)
    trap_valid && (trap_code == 4'd3) && cur_pc[0] |=> $stable(restart_o));

  a_r9_ret_outside: assert property (@(posedge clk) disable iff (rst)
    ret_valid && !trap_valid && !cur_pc[0] |=> ret_fault_o && $stable(pc_o) && $stable(shadow_o));

  a_r8_ret_restores: assert property (@(posedge clk) disable iff (rst)
    ret_valid && !trap_valid && cur_pc[0] |=> recheck_o && (pc_o == $past(restart_o)));

  a_r10_double_enter: assert property (@(posedge clk) disable iff (rst)
    trap_valid && !cur_pc[0] && shadow_o |=> swap_err_o && shadow_o);

  a_r11_trap_wins: assert property (@(posedge clk) disable iff (rst)
    trap_valid && ret_valid |=> !recheck_o && !ret_fault_o && redirect_o);
endmodule

bind trap_unit trap_unit_chk #(.PC_W(PC_W), .DW(DW), .NREG(NREG), .AW(AW)) u_chk (.*);

// File: tb/trap_unit_bench.sv
module trap_unit_bench;
  localparam int PC_W = 32;
  localparam int DW   = 32;
  localparam int NREG = 32;
  localparam int AW   = 5;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] vec_base = BASE;
  logic [PC_W-1:0] cur_pc = '0;
  logic trap_valid = 1'b0, ret_valid = 1'b0, rf_we = 1'b0;
  logic [3:0] trap_code = '0;
  logic [AW-1:0] rf_waddr = '0, rf_raddr = '0;
  logic [DW-1:0] rf_wdata = '0, rf_rdata;
  logic [PC_W-1:0] pc_o, npc_o, restart_o;
  logic shadow_o, redirect_o, recheck_o, ret_fault_o, swap_err_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trap_unit #(.PC_W(PC_W), .DW(DW), .NREG(NREG), .AW(AW)) u_trap_unit (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] off_of(input int c);
    case (c)
      0: return 32'h001;  1: return 32'h401;  2: return 32'h501;  3: return 32'h101;
      4: return 32'h201;  5: return 32'h281;  6: return 32'h301;  7: return 32'h381;
      8: return 32'h381;  9: return 32'h181; 10: return 32'h181; 11: return 32'h081;
      12: return 32'h481; 13: return 32'h581; 14: return 32'h2001; default: return 32'h501;
    endcase
  endfunction

  task automatic do_trap(input int c, input logic [31:0] pc);
    trap_valid = 1'b1; trap_code = 4'(c); cur_pc = pc;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic do_ret(input logic [31:0] pc);
    ret_valid = 1'b1; cur_pc = pc;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    rf_we = 1'b1; rf_waddr = AW'(a); rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a, input logic [31:0] exp);
    rf_raddr = AW'(a);
    @(negedge clk);
    check(req, rf_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 pc", pc_o, BASE + 32'h1);
    check("R1 npc", npc_o, BASE + 32'h5);
    check("R1 restart", restart_o, 0);
    check("R1 shadow", shadow_o, 1);
    check("R1 pulses", {redirect_o, recheck_o, ret_fault_o, swap_err_o}, 0);
  endtask

  task automatic t_vectors;
    logic [31:0] exp_rs = 32'h0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] p = 32'h0000_4001 + 32'(i * 32);
      do_trap(i, p);
      if (!(i == 3)) exp_rs = (i == 2 || i == 14 || i == 15) ? p + 4 : p;
      check($sformatf("R2 vec %0d", i), pc_o, BASE + off_of(i));
      check("R3 npc", npc_o, BASE + off_of(i) + 4);
      check($sformatf("R4/R5 restart %0d", i), restart_o, exp_rs);
      check("R2 redirect", redirect_o, 1);
      check("R6 no swap in handler", {shadow_o, swap_err_o}, 2'b10);
    end
  endtask

  task automatic t_boot_err;
    do_trap(12, 32'h8000);
    check("R10 swap_err", swap_err_o, 1);
    check("R10 shadow kept", shadow_o, 1);
    check("R10 restart still loaded", restart_o, 32'h8000);
    check("R2 pc opc", pc_o, BASE + 32'h481);
  endtask

  task automatic t_return_user;
    do_ret(BASE + 32'h481);
    check("R8 pc", pc_o, 32'h8000);
    check("R8 shadow off", shadow_o, 0);
    check("R8 recheck", recheck_o, 1);
    @(negedge clk);
    check("R8 recheck single pulse", recheck_o, 0);
  endtask

  task automatic t_retfault;
    do_ret(32'h8004);
    check("R9 fault", ret_fault_o, 1);
    check("R9 pc unchanged", pc_o, 32'h8000);
    check("R9 recheck", recheck_o, 0);
    check("R9 shadow", shadow_o, 0);
  endtask

  task automatic t_exit_err;
    do_trap(3, 32'h7001);
    check("R5 restart kept", restart_o, 32'h8000);
    check("R6 no swap", shadow_o, 0);
    do_ret(BASE + 32'h101);
    check("R10 exit err", swap_err_o, 1);
    check("R10 shadow stays off", shadow_o, 0);
    check("R8 pc restored", pc_o, 32'h8000);
  endtask

  task automatic t_regs;
    wr(8, 32'hAAAA_0008); wr(25, 32'hAAAA_0025); wr(3, 32'hCCCC_0003); wr(15, 32'hCCCC_0015);
    rd_check("R12/R7 user r8", 8, 32'hAAAA_0008);
    rd_check("R7 user r25", 25, 32'hAAAA_0025);
    rf_raddr = AW'(8);
    do_trap(14, 32'h8010);
    check("R7 read in trap cycle uses old bank", rf_rdata, 32'hAAAA_0008);
    check("R6 shadow on", shadow_o, 1);
    check("R4 call skip", restart_o, 32'h8014);
    check("R2 call vec", pc_o, BASE + 32'h2001);
    rd_check("R7 shadow r8", 8, 32'h5555_0008);
    rd_check("R7 shadow r25", 25, 32'h5555_0025);
    rd_check("R7 shared r3", 3, 32'hCCCC_0003);
    rd_check("R7 shared r15", 15, 32'hCCCC_0015);
  endtask

  task automatic t_nested_and_same;
    do_trap(3, BASE + 32'h2001);
    check("R5 nested intr", restart_o, 32'h8014);
    check("R2 intr vec", pc_o, BASE + 32'h101);
    trap_valid = 1'b1; ret_valid = 1'b1; trap_code = 4'd6; cur_pc = BASE + 32'h101;
    @(negedge clk);
    trap_valid = 1'b0; ret_valid = 1'b0;
    check("R11 trap vec", pc_o, BASE + 32'h301);
    check("R11 no recheck/fault", {recheck_o, ret_fault_o}, 0);
    check("R11 restart", restart_o, BASE + 32'h101);
    do_ret(BASE + 32'h301);
    check("R8 ret to handler pc", pc_o, BASE + 32'h101);
    check("R8 shadow kept", shadow_o, 1);
    check("R8 no err", swap_err_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    wr(8, 32'h5555_0008); wr(25, 32'h5555_0025);
    t_vectors;
    t_boot_err;
    t_return_user;
    t_retfault;
    t_exit_err;
    t_regs;
    t_nested_and_same;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule